// File: doc/BRIEF.md
# Serial receiver status and data holding front end

This block sits between a receive shift register and a processor bus. Each time the shift register finishes a character, the block either takes the character into a holding data register or, if the previous character has not been collected yet, throws the new one away and records an overrun. It also keeps a noise flag and an idle-line flag. All four status flags are collected in one status register that software reads over a simple register port.

Software clears the flags in two steps. A read of the status register arms a clear for each flag that read back as 1. The next read of the data register clears the armed flags and drops every arm. A flag that was 0 when status was read is therefore never cleared by the data read that follows, even if it became 1 in between. Overrun and noise raise an error interrupt request when their enable bits are set. The idle flag can only be raised again after a newly accepted character has re-armed it.

Top module: `rxf_front`

## Requirements
- R1: A character strobe while the full flag is 0 loads the character into the data register and sets the full flag on the next clock edge; a read at address 1 returns the held character in bits [DATA_W-1:0] with upper bits 0.
- R2: A character strobe while the full flag is 1 sets the overrun flag, discards the new character and leaves the data register unchanged.
- R3: A status read (address 0) arms a clear for each flag then reading 1; the next data read (address 1) clears every armed flag and drops all arms, whether or not it cleared anything.
- R4: A flag that read back 0 at the last status read is not cleared by a later data read, even if it was set after that status read.
- R5: The noise flag is set when a character is accepted with the noise indication high; a noise indication on a discarded character has no effect; it clears by the two-step sequence.
- R6: An idle strobe sets the idle flag only when an accepted character has occurred since reset or since the idle flag was last set; after being set, further idle strobes have no effect until a new character is accepted.
- R7: When a flag-setting event and the data read that would clear that flag occur in the same cycle, the flag is 1 after that cycle.
- R8: The error interrupt output is 1 exactly when (overrun and control bit 0) or (noise and control bit 1) are 1.
- R9: After reset all flags, all arms, the data register and the control register are 0, and the error interrupt is 0.
- R10: Status at address 0 reads full in bit 0, overrun in bit 1, noise in bit 2, idle in bit 3, other bits 0; the control register at address 2 is written and read back in bits [1:0]; address 3 reads 0; writes to other addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| char_done_i | input | 1 | One-cycle strobe: a character has finished arriving |
| char_data_i | input | DATA_W | Character from the shift register |
| char_noise_i | input | 1 | Noise was detected while this character arrived |
| line_idle_i | input | 1 | One-cycle strobe: the receive line has gone idle |
| bus_addr_i | input | 2 | Register address |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | BUS_W | Write data |
| bus_rdata_o | output | BUS_W | Read data, valid in the cycle of the read strobe |
| err_irq_o | output | 1 | Error interrupt request |

## Verification
Random traffic mixes character strobes, idle strobes and reads of every address at rates that make overruns common, so accepted characters are told apart from discarded ones by the data register value read back. Directed sequences separate a status read that saw overrun from one that did not (a late overrun must survive the following data read), put a set and its clearing read in the same cycle, and show the idle flag refusing to rise twice without a character in between. Toggling the enable bits while errors are pending shows the interrupt following each flag only through its own enable.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned N_FLAG    = 4;
  localparam int unsigned FLG_FULL  = 0;
  localparam int unsigned FLG_OVR   = 1;
  localparam int unsigned FLG_NOISE = 2;
  localparam int unsigned FLG_IDLE  = 3;

  localparam logic [1:0] ADR_STAT = 2'd0;
  localparam logic [1:0] ADR_DATA = 2'd1;
  localparam logic [1:0] ADR_CTRL = 2'd2;

  localparam int unsigned CTRL_W      = 2;
  localparam int unsigned CTL_OVR_IE  = 0;
  localparam int unsigned CTL_NZ_IE   = 1;
endpackage

// File: rtl/rxf_flag_cell.sv
// Sticky flag with a per-flag clear arm.
module rxf_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic stat_rd_i,
  input  logic data_rd_i,
  output logic flag_o
);
  logic flag_q, arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      // set wins over a same-cycle clear
      if (set_i)                   flag_q <= 1'b1;
      else if (data_rd_i && arm_q) flag_q <= 1'b0;
      if (data_rd_i)               arm_q  <= 1'b0;
      else if (stat_rd_i && flag_q) arm_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rxf_rx_hold.sv
// Accept or discard an incoming character.
module rxf_rx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              char_done_i,
  input  logic [DATA_W-1:0] char_data_i,
  input  logic              full_i,
  output logic              accept_o,
  output logic              ovr_set_o,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] data_q;

  assign accept_o  = char_done_i && !full_i;
  assign ovr_set_o = char_done_i && full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       data_q <= '0;
    else if (accept_o) data_q <= char_data_i;
  end

  assign data_o = data_q;
endmodule

// File: rtl/rxf_bus_if.sv
// Address decode, control register, read mux.
module rxf_bus_if
  import rxf_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BUS_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        bus_addr_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  input  logic [N_FLAG-1:0] flags_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              stat_rd_o,
  output logic              data_rd_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [BUS_W-1:0]  rdata_o
);
  logic [CTRL_W-1:0] ctrl_q;

  assign stat_rd_o = bus_rd_i && (bus_addr_i == ADR_STAT);
  assign data_rd_o = bus_rd_i && (bus_addr_i == ADR_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (bus_wr_i && bus_addr_i == ADR_CTRL) ctrl_q <= bus_wdata_i[CTRL_W-1:0];
  end

  always_comb begin
    rdata_o = '0;
    if (bus_rd_i) begin
      unique case (bus_addr_i)
        ADR_STAT: rdata_o[N_FLAG-1:0] = flags_i;
        ADR_DATA: rdata_o[DATA_W-1:0] = data_i;
        ADR_CTRL: rdata_o[CTRL_W-1:0] = ctrl_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/rxf_front.sv
module rxf_front
  import rxf_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BUS_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              char_done_i,
  input  logic [DATA_W-1:0] char_data_i,
  input  logic              char_noise_i,
  input  logic              line_idle_i,
  input  logic [1:0]        bus_addr_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              err_irq_o
);
  logic [N_FLAG-1:0] flags, flag_set;
  logic [DATA_W-1:0] data_q;
  logic [CTRL_W-1:0] ctrl;
  logic stat_rd, data_rd, accept, ovr_set, idle_en_q;

  rxf_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i, .rst_ni, .char_done_i, .char_data_i,
    .full_i(flags[FLG_FULL]), .accept_o(accept),
    .ovr_set_o(ovr_set), .data_o(data_q)
  );

  rxf_bus_if #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_bus (
    .clk_i, .rst_ni, .bus_addr_i, .bus_rd_i, .bus_wr_i, .bus_wdata_i,
    .flags_i(flags), .data_i(data_q), .stat_rd_o(stat_rd),
    .data_rd_o(data_rd), .ctrl_o(ctrl), .rdata_o(bus_rdata_o)
  );

  // idle may rise once per accepted character
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         idle_en_q <= 1'b0;
    else if (accept)                     idle_en_q <= 1'b1;
    else if (line_idle_i && idle_en_q)   idle_en_q <= 1'b0;
  end

  always_comb begin
    flag_set            = '0;
    flag_set[FLG_FULL]  = accept;
    flag_set[FLG_OVR]   = ovr_set;
    flag_set[FLG_NOISE] = accept && char_noise_i;
    flag_set[FLG_IDLE]  = line_idle_i && idle_en_q;
  end

  for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
    rxf_flag_cell u_cell (
      .clk_i, .rst_ni, .set_i(flag_set[g]),
      .stat_rd_i(stat_rd), .data_rd_i(data_rd), .flag_o(flags[g])
    );
  end

  assign err_irq_o = (flags[FLG_OVR] && ctrl[CTL_OVR_IE]) ||
                     (flags[FLG_NOISE] && ctrl[CTL_NZ_IE]);
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              char_done_i,
  input logic              line_idle_i,
  input logic              err_irq_o,
  input logic [3:0]        flags,
  input logic [DATA_W-1:0] data_q,
  input logic              data_rd,
  input logic              idle_en_q
);
  // R2
  ovr_on_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_done_i && flags[0]) |=> (flags[1] && $stable(data_q)));
  // R1
  full_on_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_done_i && !flags[0]) |=> flags[0]);
  // R3
  ovr_clear_by_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flags[1]) |-> $past(data_rd));
  // R6
  idle_rise_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags[3]) |-> $past(idle_en_q && line_idle_i));
  // R8
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> (flags[1] || flags[2]));
endmodule

bind rxf_front rxf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .char_done_i(char_done_i),
  .line_idle_i(line_idle_i), .err_irq_o(err_irq_o), .flags(flags),
  .data_q(data_q), .data_rd(data_rd), .idle_en_q(idle_en_q)
);

// File: tb/sim_rxf_front.sv
`timescale 1ns/1ps
module sim_rxf_front;
  localparam int DW = 8;
  localparam int BW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cd = 0, nz = 0, idl = 0, rd = 0, wr = 0;
  logic [DW-1:0] cdat = '0;
  logic [1:0] adr = '0;
  logic [BW-1:0] wdat = '0;
  logic [BW-1:0] rdata;
  logic irq;

  always #10 clk = ~clk;

  rxf_front #(.DATA_W(DW), .BUS_W(BW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .char_done_i(cd), .char_data_i(cdat),
    .char_noise_i(nz), .line_idle_i(idl), .bus_addr_i(adr), .bus_rd_i(rd),
    .bus_wr_i(wr), .bus_wdata_i(wdat), .bus_rdata_o(rdata), .err_irq_o(irq)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  logic [3:0] m_flg = '0, m_arm = '0;
  logic [DW-1:0] m_data = '0;
  logic [1:0] m_ctl = '0;
  logic m_ien = 0;

  task automatic check(string tag, logic [BW-1:0] act, logic [BW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] exp_read(logic [1:0] a);
    logic [BW-1:0] v = '0;
    case (a)
      2'd0: v[3:0] = m_flg;
      2'd1: v[DW-1:0] = m_data;
      2'd2: v[1:0] = m_ctl;
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic logic exp_irq();
    return (m_flg[1] & m_ctl[0]) | (m_flg[2] & m_ctl[1]);
  endfunction

  function automatic void model_step();
    logic [3:0] set = '0, clr = '0;
    logic acc;
    acc    = cd && !m_flg[0];
    set[0] = acc;
    set[1] = cd && m_flg[0];
    set[2] = acc && nz;
    set[3] = idl && m_ien;
    if (rd && adr == 2'd1) clr = m_arm;
    if (rd && adr == 2'd1) m_arm = '0;
    else if (rd && adr == 2'd0) m_arm = m_arm | m_flg;
    if (acc) m_data = cdat;
    if (acc) m_ien = 1'b1; else if (set[3]) m_ien = 1'b0;
    if (wr && adr == 2'd2) m_ctl = wdat[1:0];
    m_flg = set | (m_flg & ~clr);
  endfunction

  // one bus/strobe cycle; checks read data and irq before the edge
  task automatic cyc(string tag, bit c, logic [DW-1:0] d, bit n, bit i,
                     bit r, bit w, logic [1:0] a, logic [BW-1:0] wd);
    cd = c; cdat = d; nz = n; idl = i; rd = r; wr = w; adr = a; wdat = wd;
    #1;
    if (r) check(tag, rdata, exp_read(a));
    check("R8 irq", {7'd0, irq}, {7'd0, exp_irq()});
    model_step();
    @(posedge clk); @(negedge clk);
    cd = 0; nz = 0; idl = 0; rd = 0; wr = 0;
  endtask

  task automatic idle_c(); cyc("idle", 0, '0, 0, 0, 0, 0, 2'd0, '0); endtask
  task automatic rd_c(string t, logic [1:0] a); cyc(t, 0, '0, 0, 0, 1, 0, a, '0); endtask
  task automatic chr(string t, logic [DW-1:0] d, bit n); cyc(t, 1, d, n, 0, 0, 0, 2'd0, '0); endtask

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned s;
    s = $urandom(32'd2024);
    @(negedge clk); @(negedge clk);
    // R9 reset state
    check("R9 irq", {7'd0, irq}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_c("R9 status", 2'd0);
    rd_c("R9 data", 2'd1);
    rd_c("R9 ctrl", 2'd2);
    rd_c("R10 addr3", 2'd3);
    // R6: idle ignored before any character
    cyc("R6", 0, '0, 0, 1, 0, 0, 2'd0, '0);
    rd_c("R6 no idle", 2'd0);
    // R1 accept, R2 overrun
    chr("R1", 8'hA5, 0);
    rd_c("R1 data", 2'd1);
    chr("R2", 8'h3C, 0);
    rd_c("R2 status", 2'd0);
    rd_c("R2 data kept", 2'd1);
    rd_c("R3 status cleared", 2'd0);
    // R4: status read without overrun, overrun arrives, data read leaves it
    chr("R4", 8'h11, 1);
    rd_c("R4 status", 2'd0);
    chr("R4", 8'h22, 0);
    rd_c("R4 data", 2'd1);
    rd_c("R4 status", 2'd0);
    rd_c("R4 data", 2'd1);
    rd_c("R4 status", 2'd0);
    // R5 noise on discarded char ignored
    chr("R5", 8'h44, 0);
    chr("R5", 8'h55, 1);
    rd_c("R5 status", 2'd0);
    rd_c("R5 data", 2'd1);
    rd_c("R5 status", 2'd0);
    // R7: overrun set and its clearing read in one cycle
    chr("R7", 8'h66, 0);
    chr("R7", 8'h77, 0);
    rd_c("R7 status", 2'd0);
    cyc("R7", 1, 8'h88, 0, 0, 1, 0, 2'd1, '0);
    rd_c("R7 status", 2'd0);
    rd_c("R7 data", 2'd1);
    // R6 idle once per character
    cyc("R6", 0, '0, 0, 1, 0, 0, 2'd0, '0);
    rd_c("R6 status", 2'd0);
    rd_c("R6 data", 2'd1);
    cyc("R6", 0, '0, 0, 1, 0, 0, 2'd0, '0);
    rd_c("R6 no rearm", 2'd0);
    // R8 enables, R10 write
    cyc("R10 wr", 0, '0, 0, 0, 0, 1, 2'd2, 8'hFF);
    rd_c("R10 ctrl", 2'd2);
    cyc("R10 wr other", 0, '0, 0, 0, 0, 1, 2'd1, 8'h00);
    rd_c("R10 data", 2'd1);
    // random traffic
    for (int k = 0; k < 4000; k++) begin
      bit c, n, i, r, w;
      logic [1:0] a;
      string t;
      c = ($urandom % 4) == 0;
      n = ($urandom % 3) == 0;
      i = ($urandom % 8) == 0;
      r = ($urandom % 3) == 0;
      w = !r && (($urandom % 16) == 0);
      a = 2'($urandom);
      case (a)
        2'd0: t = "R3 status";
        2'd1: t = "R1 data";
        2'd2: t = "R10 ctrl";
        default: t = "R10 addr3";
      endcase
      cyc(t, c, DW'($urandom), n, i, r, w, a, BW'($urandom));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule